// File: doc/BRIEF.md
# Multi-level page table walker

This block turns a 32-bit logical address and a 3-bit function code into a physical address by walking a tree of in-memory descriptor tables. One 32-bit control word sets the walk's geometry: a page-size field, a count of leading address bits to skip, and four per-level index widths. It also holds an enable that lets supervisor accesses start from their own root. The walker can stop early at any level when it finds a page descriptor. It reports an invalid status, with the level where the walk stopped, when it reaches an invalid descriptor.

Two shortcuts skip the walk entirely. Accesses with function code 7 are passed through unchanged. Each of a set of transparent-translation words can also match an address window and a function-code pattern. A match returns the address untouched one cycle after the request.

Table reads go out on a simple port. The walker holds the request and address until the response valid arrives. Each result comes back as a single-cycle done pulse carrying the address and status.

Top module: `ptw_walker`

## Requirements
- R1: A request accepted while idle with function code 7 completes one cycle later with phys_addr equal to the logical address, no fault, and no table read.
- R2: A transparent-translation word hits when bit 15 is set, (addr[31:24] AND NOT word[23:16]) equals word[31:24], and (fc AND NOT word[2:0]) equals word[6:4]. A hit on any word completes one cycle after the request with the address unchanged and no table read.
- R3: A word with bit 15 clear, or whose function-code test fails, does not bypass, and the walk proceeds.
- R4: The walk starts from sup_root when control bit 25 is set and fc[2] is 1. In every other case it starts from cpu_root.
- R5: Control fields are page size [23:20], skipped bits [19:16], and index widths for levels 0..3 at [15:12], [11:8], [7:4] and [3:0]. At level L the index is the address shifted left by skipped bits plus the widths of the earlier levels, then right by 32 minus the width of level L. A width of 0 gives index 0. For a descriptor of type 2, the next read goes to (descriptor with bits 3:0 cleared) + index×4. For type 3 it goes to that base + index×8.
- R6: mem_req stays high with mem_addr unchanged until mem_rvalid is seen.
- R7: A descriptor of type 0 (bits 1:0) at level L ends the walk with fault_invalid=1 and fault_level=L. The root counts as level 0.
- R8: A descriptor of type 1 at any level L ends the walk. phys_addr is (descriptor AND (all-ones shifted left by page size)) plus the logical address with its top (skipped bits + widths of levels before L) bits cleared.
- R9: A table descriptor (type 2 or 3) met at level 3 ends the walk with fault_depth=1, fault_level=3, and no further read.
- R10: done is high for exactly one cycle per accepted request. A request presented while busy is ignored.
- R11: After reset, done, mem_req and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a translation (taken only while idle) |
| req_addr | input | 32 | Logical address |
| req_fc | input | 3 | Function code |
| tc_word | input | 32 | Walk geometry and supervisor-root enable |
| tt_words | input | 64 | Transparent-translation words, word k at [32k+31:32k] |
| sup_root | input | 32 | Supervisor root descriptor |
| cpu_root | input | 32 | Default root descriptor |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Table read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response descriptor |
| done | output | 1 | Result valid pulse |
| phys_addr | output | 32 | Translated address (0 on a fault) |
| fault_invalid | output | 1 | Walk hit an invalid descriptor |
| fault_depth | output | 1 | Walk ran out of levels |
| fault_level | output | 2 | Level at which the walk stopped |

## Verification
A bypass result is due one cycle after the accepting edge. A walk that ends at the root is due two cycles after that edge. Each table read adds one cycle for evaluation plus the cycle in which the response is taken, plus any extra response delay. The bench drives inputs and samples outputs on the falling edge and counts cycles from the accepting edge, so the one- and two-cycle latencies are checked exactly. For longer walks, the bench waits for done and checks the read addresses in the order they were issued. It keeps sampling for several cycles after each done to confirm the pulse does not repeat. During delayed responses it compares mem_addr on every waiting cycle.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
  typedef enum logic [1:0] {
    PW_IDLE = 2'd0,
    PW_EVAL = 2'd1,
    PW_READ = 2'd2
  } pw_state_e;

  localparam logic [1:0] DT_INVALID = 2'd0;
  localparam logic [1:0] DT_PAGE    = 2'd1;
  localparam logic [1:0] DT_SHORT   = 2'd2;
  localparam logic [1:0] DT_LONG    = 2'd3;

  localparam int SRE_BIT = 25;
  localparam int TT_EN_BIT = 15;
endpackage

// File: rtl/ptw_tt_match.sv
`timescale 1ns/1ps
module ptw_tt_match (
  input  logic [31:0] addr,
  input  logic [2:0]  fc,
  input  logic [31:0] tt,
  output logic        hit
);
  logic [7:0] keep_bits;
  logic       addr_ok;
  logic       fc_ok;

  always_comb begin
    keep_bits = ~tt[23:16];
    addr_ok   = ((addr[31:24] & keep_bits) == tt[31:24]);
    fc_ok     = ((fc & ~tt[2:0]) == tt[6:4]);
    hit       = tt[ptw_pkg::TT_EN_BIT] && addr_ok && fc_ok;
  end
endmodule

// File: rtl/ptw_bypass.sv
`timescale 1ns/1ps
module ptw_bypass #(
  parameter int NUM_TT = 2
) (
  input  logic [31:0]          addr,
  input  logic [2:0]           fc,
  input  logic [NUM_TT*32-1:0] tt_words,
  output logic                 pass
);
  logic [NUM_TT-1:0] hits;

  for (genvar k = 0; k < NUM_TT; k++) begin : g_tt
    ptw_tt_match u_match (
      .addr (addr),
      .fc   (fc),
      .tt   (tt_words[k*32 +: 32]),
      .hit  (hits[k])
    );
  end

  assign pass = (fc == 3'd7) || (|hits);
endmodule

// File: rtl/ptw_level_calc.sv
`timescale 1ns/1ps
module ptw_level_calc (
  input  logic [31:0] addr,
  input  logic [31:0] desc,
  input  logic [31:0] tc_word,
  input  logic [1:0]  level,
  output logic [31:0] next_addr,
  output logic [31:0] page_addr
);
  logic [6:0]  consumed;
  logic [3:0]  width;
  logic [31:0] shifted;
  logic [31:0] index;
  logic [31:0] offset;
  logic [31:0] page_mask;
  logic [6:0]  f_is, f_a, f_b, f_c;

  always_comb begin
    f_is = {3'b0, tc_word[19:16]};
    f_a  = {3'b0, tc_word[15:12]};
    f_b  = {3'b0, tc_word[11:8]};
    f_c  = {3'b0, tc_word[7:4]};
    case (level)
      2'd0:    begin consumed = f_is;                 width = tc_word[15:12]; end
      2'd1:    begin consumed = f_is + f_a;           width = tc_word[11:8];  end
      2'd2:    begin consumed = f_is + f_a + f_b;     width = tc_word[7:4];   end
      default: begin consumed = f_is + f_a + f_b + f_c; width = tc_word[3:0]; end
    endcase

    if (consumed >= 7'd32) begin
      shifted = '0;
      offset  = '0;
    end else begin
      shifted = addr << consumed[4:0];
      offset  = shifted >> consumed[4:0];
    end

    if (width == 4'd0) index = '0;
    else               index = shifted >> (6'd32 - {2'b00, width});

    next_addr = {desc[31:4], 4'b0000} + (desc[0] ? (index << 3) : (index << 2));
    page_mask = 32'hFFFF_FFFF << tc_word[23:20];
    page_addr = (desc & page_mask) + offset;
  end
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker #(
  parameter int NUM_TT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [31:0]          req_addr,
  input  logic [2:0]           req_fc,
  input  logic [31:0]          tc_word,
  input  logic [NUM_TT*32-1:0] tt_words,
  input  logic [31:0]          sup_root,
  input  logic [31:0]          cpu_root,
  output logic                 busy,
  output logic                 mem_req,
  output logic [31:0]          mem_addr,
  input  logic                 mem_rvalid,
  input  logic [31:0]          mem_rdata,
  output logic                 done,
  output logic [31:0]          phys_addr,
  output logic                 fault_invalid,
  output logic                 fault_depth,
  output logic [1:0]           fault_level
);
  import ptw_pkg::*;

  localparam logic [1:0] LAST_LVL = 2'd3;

  pw_state_e   state_q, state_d;
  logic [31:0] addr_q, desc_q, desc_d, rd_q, rd_d;
  logic [1:0]  lvl_q, lvl_d;
  logic        done_d, inv_d, deep_d;
  logic [31:0] phys_d;
  logic [1:0]  flvl_d;
  logic        accept, pass, use_sup;
  logic [31:0] next_addr, page_addr;
  logic [31:0] unused_tc;

  assign unused_tc = {tc_word[31:26], tc_word[24], 25'd0};
  assign accept  = (state_q == PW_IDLE) && req_valid;
  assign use_sup = tc_word[SRE_BIT] && req_fc[2];

  ptw_bypass #(.NUM_TT(NUM_TT)) u_bypass (
    .addr     (req_addr),
    .fc       (req_fc),
    .tt_words (tt_words),
    .pass     (pass)
  );

  ptw_level_calc u_calc (
    .addr      (addr_q),
    .desc      (desc_q),
    .tc_word   (tc_word),
    .level     (lvl_q),
    .next_addr (next_addr),
    .page_addr (page_addr)
  );

  always_comb begin
    state_d = state_q;
    desc_d  = desc_q;
    rd_d    = rd_q;
    lvl_d   = lvl_q;
    done_d  = 1'b0;
    inv_d   = fault_invalid;
    deep_d  = fault_depth;
    phys_d  = phys_addr;
    flvl_d  = fault_level;
    case (state_q)
      PW_IDLE: begin
        if (req_valid) begin
          if (pass) begin
            done_d = 1'b1;
            phys_d = req_addr;
            inv_d  = 1'b0;
            deep_d = 1'b0;
            flvl_d = 2'd0;
          end else begin
            desc_d  = use_sup ? sup_root : cpu_root;
            lvl_d   = 2'd0;
            state_d = PW_EVAL;
          end
        end
      end
      PW_EVAL: begin
        case (desc_q[1:0])
          DT_INVALID: begin
            done_d = 1'b1; phys_d = '0; inv_d = 1'b1; deep_d = 1'b0;
            flvl_d = lvl_q; state_d = PW_IDLE;
          end
          DT_PAGE: begin
            done_d = 1'b1; phys_d = page_addr; inv_d = 1'b0; deep_d = 1'b0;
            flvl_d = lvl_q; state_d = PW_IDLE;
          end
          default: begin
            if (lvl_q == LAST_LVL) begin
              done_d = 1'b1; phys_d = '0; inv_d = 1'b0; deep_d = 1'b1;
              flvl_d = LAST_LVL; state_d = PW_IDLE;
            end else begin
              rd_d    = next_addr;
              state_d = PW_READ;
            end
          end
        endcase
      end
      PW_READ: begin
        if (mem_rvalid) begin
          desc_d  = mem_rdata;
          lvl_d   = lvl_q + 2'd1;
          state_d = PW_EVAL;
        end
      end
      default: state_d = PW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= PW_IDLE;
      addr_q        <= '0;
      desc_q        <= '0;
      rd_q          <= '0;
      lvl_q         <= '0;
      done          <= 1'b0;
      phys_addr     <= '0;
      fault_invalid <= 1'b0;
      fault_depth   <= 1'b0;
      fault_level   <= '0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
      if (accept) addr_q <= req_addr;
      desc_q <= desc_d;
      lvl_q  <= lvl_d;
      rd_q   <= rd_d;
      if (done_d) begin
        phys_addr     <= phys_d;
        fault_invalid <= inv_d;
        fault_depth   <= deep_d;
        fault_level   <= flvl_d;
      end
    end
  end

  assign busy     = (state_q != PW_IDLE);
  assign mem_req  = (state_q == PW_READ);
  assign mem_addr = rd_q;

  // R1
  fc7_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_fc == 3'd7) |=> (done && phys_addr == $past(req_addr) && !fault_invalid && !fault_depth));
  // R6
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_req));
  // R9
  depth_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_depth) |-> (fault_level == 2'd3 && !fault_invalid));
endmodule

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
  logic        clk, rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [2:0]  req_fc;
  logic [31:0] tc_word;
  logic [63:0] tt_words;
  logic [31:0] sup_root, cpu_root;
  logic        busy, mem_req, mem_rvalid, done;
  logic [31:0] mem_addr, mem_rdata, phys_addr;
  logic        fault_invalid, fault_depth;
  logic [1:0]  fault_level;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_a [16];
  logic [31:0] m_d [16];
  int          m_n;

  logic [31:0] r_phys;
  logic        r_inv, r_deep;
  logic [1:0]  r_lvl;
  int          r_reads, r_lat, r_dones;
  logic        r_unstable;
  logic [31:0] r_raddr [4];

  ptw_walker #(.NUM_TT(2)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_fc(req_fc), .tc_word(tc_word), .tt_words(tt_words),
    .sup_root(sup_root), .cpu_root(cpu_root), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .done(done), .phys_addr(phys_addr),
    .fault_invalid(fault_invalid), .fault_depth(fault_depth),
    .fault_level(fault_level)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic mem_clear();
    m_n = 0;
  endtask

  task automatic mem_put(input logic [31:0] a, input logic [31:0] d);
    m_a[m_n] = a; m_d[m_n] = d; m_n++;
  endtask

  function automatic logic [31:0] mem_get(input logic [31:0] a);
    for (int i = 0; i < m_n; i++) if (m_a[i] == a) return m_d[i];
    return 32'h0;
  endfunction

  task automatic walk(input logic [31:0] addr, input logic [2:0] fc, input int lat, input bit poke);
    int cyc, wcnt;
    logic [31:0] prev;
    bit have_prev;
    r_reads = 0; r_dones = 0; r_unstable = 0; r_lat = -1;
    wcnt = 0; have_prev = 0; prev = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_fc = fc;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (cyc < 200) begin
      mem_rvalid = 1'b0;
      if (done) begin
        r_lat = cyc; r_phys = phys_addr; r_inv = fault_invalid;
        r_deep = fault_depth; r_lvl = fault_level; r_dones = 1;
        break;
      end
      if (mem_req) begin
        if (have_prev && mem_addr != prev) r_unstable = 1'b1;
        prev = mem_addr; have_prev = 1'b1;
        if (wcnt == lat) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem_get(mem_addr);
          if (r_reads < 4) r_raddr[r_reads] = mem_addr;
          r_reads++;
          wcnt = 0; have_prev = 1'b0;
        end else wcnt++;
      end
      if (poke && cyc == 2) begin
        req_valid = 1'b1; req_fc = 3'd7; req_addr = 32'hDEAD_BEEF;
      end else req_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0; mem_rvalid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done) r_dones++;
    end
  endtask

  task automatic test_reset();
    chk(!done,    "R11 done after reset",    {31'd0, done}, 32'd0);
    chk(!mem_req, "R11 mem_req after reset", {31'd0, mem_req}, 32'd0);
    chk(!busy,    "R11 busy after reset",    {31'd0, busy}, 32'd0);
  endtask

  task automatic test_fc7();
    walk(32'h1234_5678, 3'd7, 0, 0);
    chk(r_lat == 1, "R1 fc7 latency", r_lat, 1);
    chk(r_phys == 32'h1234_5678, "R1 fc7 phys", r_phys, 32'h1234_5678);
    chk(r_reads == 0 && !r_inv && !r_deep, "R1 fc7 no read/no fault", r_reads, 0);
    chk(r_dones == 1, "R10 single done", r_dones, 1);
  endtask

  task automatic test_tt_hits();
    tt_words[31:0] = 32'h400F_8010;
    walk(32'h4A12_3456, 3'd1, 0, 0);
    chk(r_lat == 1 && r_reads == 0, "R2 tt0 bypass latency", r_lat, 1);
    chk(r_phys == 32'h4A12_3456, "R2 tt0 phys", r_phys, 32'h4A12_3456);
    tt_words[31:0]  = 32'h0;
    tt_words[63:32] = 32'h8000_8007;
    walk(32'h8000_1000, 3'd5, 0, 0);
    chk(r_lat == 1 && r_phys == 32'h8000_1000, "R2 tt1 bypass any fc", r_phys, 32'h8000_1000);
    tt_words = '0;
  endtask

  task automatic test_tt_miss();
    cpu_root = 32'h0;
    tt_words[31:0] = 32'h400F_0010;
    walk(32'h4A12_3456, 3'd1, 0, 0);
    chk(r_lat == 2 && r_inv, "R3 disabled tt walks", r_lat, 2);
    chk(r_lvl == 2'd0, "R7 root invalid level", r_lvl, 0);
    chk(r_phys == 32'h0, "R7 fault phys zero", r_phys, 0);
    tt_words[31:0] = 32'h400F_8010;
    walk(32'h4A12_3456, 3'd2, 0, 0);
    chk(r_lat == 2 && r_inv && r_lvl == 2'd0, "R3 fc mismatch walks", r_lat, 2);
    tt_words = '0;
  endtask

  task automatic test_two_level();
    tc_word  = 32'h02C0_8C00;
    cpu_root = 32'h0001_0002;
    mem_clear();
    mem_put(32'h0001_0048, 32'h0002_0002);
    mem_put(32'h0002_0D14, 32'h0ABC_D001);
    walk(32'h1234_5678, 3'd1, 0, 0);
    chk(r_reads == 2, "R5 two reads", r_reads, 2);
    chk(r_raddr[0] == 32'h0001_0048, "R5 level0 short index", r_raddr[0], 32'h0001_0048);
    chk(r_raddr[1] == 32'h0002_0D14, "R5 level1 short index", r_raddr[1], 32'h0002_0D14);
    chk(r_phys == 32'h0ABC_D678 && !r_inv && !r_deep, "R8 page at level2", r_phys, 32'h0ABC_D678);
    chk(r_lvl == 2'd2, "R8 page level", r_lvl, 2);
  endtask

  task automatic test_root_select();
    tc_word  = 32'h02C0_8C00;
    sup_root = 32'h0003_0003;
    cpu_root = 32'h7000_0001;
    mem_clear();
    mem_put(32'h0003_0090, 32'h5500_0001);
    walk(32'h1234_5678, 3'd5, 0, 0);
    chk(r_reads == 1 && r_raddr[0] == 32'h0003_0090, "R4 R5 supervisor root long index", r_raddr[0], 32'h0003_0090);
    chk(r_phys == 32'h5534_5678, "R8 early page level1", r_phys, 32'h5534_5678);
    tc_word = 32'h00C0_8C00;
    walk(32'h1234_5678, 3'd5, 0, 0);
    chk(r_reads == 0 && r_phys == 32'h8234_5678, "R4 no enable uses cpu root", r_phys, 32'h8234_5678);
    chk(r_lat == 2, "R8 root page latency", r_lat, 2);
  endtask

  task automatic test_invalid_mid();
    tc_word  = 32'h00C0_8C00;
    cpu_root = 32'h0001_0002;
    mem_clear();
    mem_put(32'h0001_004C, 32'h0004_0002);
    walk(32'h1300_0000, 3'd1, 0, 0);
    chk(r_reads == 2 && r_raddr[1] == 32'h0004_0000, "R5 zero index read", r_raddr[1], 32'h0004_0000);
    chk(r_inv && !r_deep && r_lvl == 2'd2, "R7 invalid at level2", r_lvl, 2);
  endtask

  task automatic test_depth();
    tc_word  = 32'h0080_8888;
    cpu_root = 32'h0005_0002;
    mem_clear();
    mem_put(32'h0005_0004, 32'h0006_0002);
    mem_put(32'h0006_0004, 32'h0007_0002);
    mem_put(32'h0007_0004, 32'h0008_0002);
    walk(32'h0101_0101, 3'd1, 0, 0);
    chk(r_reads == 3, "R9 no fourth read", r_reads, 3);
    chk(r_deep && !r_inv && r_lvl == 2'd3, "R9 depth fault", {30'd0, r_lvl}, 3);
  endtask

  task automatic test_skip_latency();
    tc_word  = 32'h00C4_44C8;
    cpu_root = 32'h0009_0002;
    mem_clear();
    mem_put(32'h0009_0004, 32'h000A_0003);
    mem_put(32'h000A_0010, 32'h0BB0_0001);
    walk(32'hF123_4567, 3'd2, 3, 1);
    chk(!r_unstable, "R6 request held stable", {31'd0, r_unstable}, 0);
    chk(r_reads == 2 && r_raddr[1] == 32'h000A_0010, "R5 skipped bits long read", r_raddr[1], 32'h000A_0010);
    chk(r_phys == 32'h0BB3_4567, "R8 page with skipped bits", r_phys, 32'h0BB3_4567);
    chk(r_dones == 1, "R10 busy request ignored", r_dones, 1);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_fc = '0;
    tc_word = '0; tt_words = '0; sup_root = '0; cpu_root = '0;
    mem_rvalid = 1'b0; mem_rdata = '0; m_n = 0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_fc7();
    test_tt_hits();
    test_tt_miss();
    test_two_level();
    test_root_select();
    test_invalid_mid();
    test_depth();
    test_skip_latency();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule